// File: doc/BRIEF.md
# Serial-Loaded Trim Channel Bank

This block is the digital front end of a twelve-channel, 8-bit trim converter. A host sends frames over a three-wire serial link made of an active-low select, a serial clock and a data line. Each frame writes one 8-bit value into one of twelve channel registers. Every channel register drives its own parallel 8-bit output, which feeds the analog ladders outside this block.

The three serial pins and the shutdown pin are brought into the system clock domain through a synchronizer, and edges are detected in that domain. Each rising serial-clock edge seen while select is low moves one data bit, MSB first, into a twelve-bit shift register. When select rises, the shift register is read as a 4-bit channel address followed by an 8-bit value, and only the addressed channel is written. A frame can have any length, because only the twelve most recent bits are used. A host that sends whole bytes can therefore send 16 bits with four leading filler bits. An asynchronous reset sets every channel to midscale. A shutdown input raises a flag that marks all outputs as open-circuit.

Top module: `serial_trim_bank`

## Requirements
- R1: Serial-clock rising edges that occur while select is high do not change the shift register. A later short frame shows this, because it commits whatever the shift register holds at that point.
- R2: While select is low, each serial-clock rising edge shifts in one bit from the data pin, MSB first. Of the retained 12 bits, bits [11:8] are the channel address and bits [7:0] are the value.
- R3: A frame longer than 12 bits commits only its last 12 bits. This holds for 16-bit and 20-bit frames.
- R4: When select rises, address code k in the range 0..11 writes the value field to channel k. Channel k appears on `chan_val_o[k*8 +: 8]`.
- R5: A commit changes only the addressed channel. All other channels keep their values.
- R6: The asynchronous reset sets all twelve channels to 128 (0x80), clears the shift register to zero and clears `out_open_o`. This applies at start-up and during operation.
- R7: Address codes 12 to 15 leave all channels unchanged.
- R8: While `shdn_i` is high, `out_open_o` is 1. Shutdown does not change the channel values, and writes are still accepted during shutdown. `out_open_o` returns to 0 when `shdn_i` falls.
- R9: A frame with fewer than 12 clocks, including a frame with none, commits the current shift-register contents. Those contents are the earlier bits shifted left by the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. All pins are sampled in this domain. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| sclk_i | input | 1 | Serial clock. Bits are shifted on its rising edge. |
| csn_i | input | 1 | Active-low frame select. Its rising edge commits the frame. |
| sdin_i | input | 1 | Serial data, MSB first. |
| shdn_i | input | 1 | Shutdown request. |
| chan_val_o | output | 96 | Twelve 8-bit channel values. Channel k is at bits [k*8+7:k*8]. |
| out_open_o | output | 1 | Flag marking all outputs as open-circuit. |

## Verification
The bench builds the block with its default parameters: twelve channels, 8-bit values, a 4-bit address and a two-stage synchronizer. With a 4-bit address, four unused codes are left over, so the ignored-address path can be reached. Every serial phase is held for four system clocks, so each pin edge is well clear of the synchronizer. This makes ordering effects observable, such as clocks with select high followed by a short frame, and frames of 0, 4, 12, 16 and 20 bits.

// File: rtl/trim_pkg.sv
package trim_pkg;
    localparam int DEF_CHANNELS = 12;
    localparam int DEF_VAL_W    = 8;
    localparam int DEF_ADDR_W   = 4;
    localparam int DEF_SYNC     = 2;

    // index of each pin inside the synchronized bus
    localparam int PIN_SCLK = 0;
    localparam int PIN_CSN  = 1;
    localparam int PIN_SDIN = 2;
    localparam int PIN_SHDN = 3;
    localparam int PIN_COUNT = 4;
endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/edge_rise.sv
module edge_rise #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise_i,
    input  logic          sel_n_i,
    input  logic          din_i,
    output logic [FW-1:0] frame_o
);
    typedef struct packed {
        logic [FW-1:0] sr;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic shift_en;

    assign shift_en = sclk_rise_i & ~sel_n_i;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[FW-2:0], din_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o = st_q.sr;

    // R1: with select inactive the shift register holds
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_i |=> $stable(frame_o));

    // R2: a qualified edge appends the data bit at the LSB end
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise_i && !sel_n_i) |=> (frame_o[0] == $past(din_i)) &&
                                      (frame_o[FW-1:1] == $past(frame_o[FW-2:0])));
endmodule

// File: rtl/chan_bank.sv
module chan_bank #(
    parameter int NCH    = 12,
    parameter int VAL_W  = 8,
    parameter int ADDR_W = 4,
    localparam int FW    = ADDR_W + VAL_W,
    localparam logic [VAL_W-1:0] MID = VAL_W'(1) << (VAL_W-1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_i,
    input  logic [FW-1:0]             frame_i,
    output logic [NCH-1:0][VAL_W-1:0] bank_o
);
    typedef struct packed {
        logic [NCH-1:0][VAL_W-1:0] regs;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [ADDR_W-1:0] addr;
    logic [VAL_W-1:0]  value;
    logic [NCH-1:0]    hit;

    assign addr  = frame_i[FW-1 -: ADDR_W];
    assign value = frame_i[VAL_W-1:0];

    for (genvar k = 0; k < NCH; k++) begin : g_dec
        assign hit[k] = commit_i && (addr == ADDR_W'(k));
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NCH; k++) begin
            if (hit[k]) begin
                st_d.regs[k] = value;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs <= {NCH{MID}};
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o = st_q.regs;

    // R5: nothing changes without a commit strobe
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(bank_o));

    // R7: out-of-range codes leave every channel untouched
    p_bad_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (int'(addr) >= NCH)) |=> $stable(bank_o));

    // R4: a valid commit lands the value in the addressed channel
    p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (int'(addr) < NCH)) |=> bank_o[$past(addr)] == $past(value));
endmodule

// File: rtl/serial_trim_bank.sv
module serial_trim_bank #(
    parameter int NCH    = trim_pkg::DEF_CHANNELS,
    parameter int VAL_W  = trim_pkg::DEF_VAL_W,
    parameter int ADDR_W = trim_pkg::DEF_ADDR_W,
    parameter int SYNC   = trim_pkg::DEF_SYNC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 csn_i,
    input  logic                 sdin_i,
    input  logic                 shdn_i,
    output logic [NCH*VAL_W-1:0] chan_val_o,
    output logic                 out_open_o
);
    import trim_pkg::*;

    localparam int FW = ADDR_W + VAL_W;
    localparam logic [PIN_COUNT-1:0] PIN_RST = 4'b0011;

    logic [PIN_COUNT-1:0]       pins_raw, pins_sync;
    logic                       sclk_rise, csn_rise;
    logic [FW-1:0]              frame;
    logic [NCH-1:0][VAL_W-1:0]  bank;

    assign pins_raw = {shdn_i, sdin_i, csn_i, sclk_i};

    sync_bus #(.W(PIN_COUNT), .STAGES(SYNC), .RST_VAL(PIN_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .level_o (pins_sync)
    );

    edge_rise #(.RST_VAL(1'b1)) u_sclk_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pins_sync[PIN_SCLK]),
        .rise_o  (sclk_rise)
    );

    edge_rise #(.RST_VAL(1'b1)) u_csn_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pins_sync[PIN_CSN]),
        .rise_o  (csn_rise)
    );

    frame_shifter #(.FW(FW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .sel_n_i     (pins_sync[PIN_CSN]),
        .din_i       (pins_sync[PIN_SDIN]),
        .frame_o     (frame)
    );

    chan_bank #(.NCH(NCH), .VAL_W(VAL_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (csn_rise),
        .frame_i  (frame),
        .bank_o   (bank)
    );

    assign chan_val_o = bank;
    assign out_open_o = pins_sync[PIN_SHDN];

    // R8: the shutdown flag never disturbs stored channel values
    p_shdn_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_open_o && !csn_rise) |=> $stable(chan_val_o));
endmodule

// File: tb/serial_trim_bank_tb_top.sv
module serial_trim_bank_tb_top;
    localparam int NCH = 12;
    localparam int VW  = 8;

    typedef struct {
        logic [NCH*VW-1:0] vals;
        logic              open;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_i = 1'b1;
    logic csn_i = 1'b1;
    logic sdin_i = 1'b0;
    logic shdn_i = 1'b0;
    logic [NCH*VW-1:0] chan_val_o;
    logic out_open_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]  mdl_ch [NCH];
    logic [11:0] mdl_sr;
    logic        mdl_open;
    exp_t        sb_q [$];

    always #5 clk = ~clk;

    serial_trim_bank dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i),
        .sdin_i(sdin_i), .shdn_i(shdn_i),
        .chan_val_o(chan_val_o), .out_open_o(out_open_o)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        for (int k = 0; k < NCH; k++) mdl_ch[k] = 8'h80;
        mdl_sr = '0;
        mdl_open = 1'b0;
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        for (int k = 0; k < NCH; k++) e.vals[k*VW +: VW] = mdl_ch[k];
        e.open = mdl_open;
        e.tag = tag;
        sb_q.push_back(e);
        wait_clk(16);
    endtask

    task automatic send_frame(input logic [31:0] bits, input int n, input string tag);
        csn_i = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sclk_i = 1'b0;
            sdin_i = bits[i];
            wait_clk(4);
            sclk_i = 1'b1;
            mdl_sr = {mdl_sr[10:0], bits[i]};
            wait_clk(4);
        end
        csn_i = 1'b1;
        wait_clk(4);
        if (mdl_sr[11:8] < 4'd12) mdl_ch[mdl_sr[11:8]] = mdl_sr[7:0];
        push_exp(tag);
    endtask

    // monitor: pop and compare once the design has settled
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                repeat (10) @(negedge clk);
                e = sb_q.pop_front();
                checks++;
                if (chan_val_o !== e.vals) begin
                    errors++;
                    $display("FAIL %s: chan_val_o=%h expected %h", e.tag, chan_val_o, e.vals);
                end
                checks++;
                if (out_open_o !== e.open) begin
                    errors++;
                    $display("FAIL %s: out_open_o=%b expected %b", e.tag, out_open_o, e.open);
                end
            end
        end
    end

    initial begin
        model_reset();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        push_exp("R6 reset midscale");

        send_frame({20'h0, 4'd0, 8'h5A}, 12, "R2 R4 channel 0 write");
        send_frame({20'h0, 4'd11, 8'hC3}, 12, "R4 R5 channel 11 write");
        send_frame({16'h0, 4'hF, 4'd5, 8'h77}, 16, "R3 16-bit frame");
        send_frame({12'h0, 8'hA5, 4'd3, 8'h01}, 20, "R3 20-bit frame");
        send_frame({20'h0, 4'd12, 8'h00}, 12, "R7 address 12 ignored");
        send_frame({20'h0, 4'd15, 8'hEE}, 12, "R7 address 15 ignored");

        send_frame({20'h0, 4'd2, 8'h44}, 12, "R4 channel 2 write");
        sdin_i = 1'b1;
        for (int p = 0; p < 8; p++) begin
            sclk_i = 1'b0;
            wait_clk(4);
            sclk_i = 1'b1;
            wait_clk(4);
        end
        send_frame(32'h0, 4, "R1 R9 clocks with select high then 4-bit frame");
        send_frame(32'h0, 0, "R9 empty frame recommits");

        shdn_i = 1'b1;
        mdl_open = 1'b1;
        wait_clk(4);
        push_exp("R8 shutdown flag, values kept");
        send_frame({20'h0, 4'd7, 8'h99}, 12, "R8 write during shutdown");
        shdn_i = 1'b0;
        mdl_open = 1'b0;
        wait_clk(4);
        push_exp("R8 shutdown released");

        rst_n = 1'b0;
        wait_clk(3);
        model_reset();
        rst_n = 1'b1;
        wait_clk(2);
        push_exp("R6 reset during operation");
        send_frame(32'h0, 0, "R6 R9 shift register cleared by reset");

        wait_clk(20);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule